// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block buffers data words between two unrelated clock domains. A write port on one clock stores words into a dual-port array. A read port on a second clock takes them out in order. Each pointer crosses to the other domain as a Gray code with one extra wrap bit. It passes through two register stages before any flag uses it.

The full reset samples a mode select. In standard mode a stored word reaches the output only after an explicit read. In fall-through mode a prefetch output register is loaded without a read, and the read strobe consumes it. One flag output on each side changes meaning with the mode. The almost-empty and almost-full thresholds arrive as inputs from a separate offset-programming block.

A partial reset (flush) empties the buffer and keeps the latched mode. A retransmit request rewinds the read pointer to the first location so that the data can be read again. Retransmit is only valid while the write port is idle and no location has been overwritten since the last reset or flush.

Top module: `dcfifo_ft`

## Requirements
- R1: The mode is sampled from `fwft_sel` (0 = standard, 1 = fall-through) on every write-clock and read-clock edge while `rst_n` is low. Changes on `fwft_sel` while `rst_n` is high have no effect.
- R2: In standard mode a written word does not appear on `rd_data` until a read is accepted. An accepted read updates `rd_data` at the read-clock edge that samples `rd_en`.
- R3: In fall-through mode the first word written into an empty FIFO appears on `rd_data` with `rd_flag` = 1 and no read. Each accepted read replaces it with the next stored word at that same edge. `rd_flag` falls when the last word is consumed.
- R4: In standard mode, `rd_flag` = 1 means empty and `wr_flag` = 1 means full. In fall-through mode, `rd_flag` = 1 means output data valid and `wr_flag` = 1 means space available.
- R5: `rd_aempty` is 1 when the number of stored words, including a word held in the prefetch register, is at or below `ae_lvl`.
- R6: `wr_afull` is 1 when the number of words held in the array exceeds 2^AW − `af_lvl`.
- R7: A write cannot change the read-side flags before its pointer has passed two read-clock register stages. A read cannot change the write-side flags before two write-clock stages.
- R8: Full reset returns both pointers to the first location. It clears `rd_data` and leaves the flags in their empty state for the sampled mode, with `rd_aempty` = 1 and `wr_afull` = 0.
- R9: A low `flush_n` (partial reset) empties the FIFO and returns both pointers to the first location, while keeping the latched mode.
- R10: While `rt_en` = 1, a low `rt_n` rewinds the read pointer to the first location. While `rt_en` = 0, `rt_n` has no effect.
- R11: A write while the array is full and a read while nothing is readable are both ignored. Neither moves a pointer, and `rd_data` is unchanged.
- R12: In fall-through mode the FIFO accepts 2^AW + 1 words (the array plus the prefetch register) before `wr_flag` drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, active low, synchronous to each clock |
| flush_n | input | 1 | Partial reset (flush), active low |
| fwft_sel | input | 1 | Mode select sampled during full reset (1 = fall-through) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| af_lvl | input | AW+1 | Almost-full offset from the full boundary |
| wr_flag | output | 1 | Full (standard) or space available (fall-through) |
| wr_afull | output | 1 | Almost-full flag |
| rd_en | input | 1 | Read strobe |
| ae_lvl | input | AW+1 | Almost-empty offset |
| rt_en | input | 1 | Retransmit mode enable |
| rt_n | input | 1 | Retransmit request, active low |
| rd_data | output | DW | Output data register |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| rd_aempty | output | 1 | Almost-empty flag |

## Verification
A read result is due on `rd_data` at the read-clock edge that accepts the strobe. The bench therefore samples it at the next read-clock falling edge. A flag in the opposite domain needs two synchronizer stages plus its own register, which is three edges of that domain. The bench checks that a flag has not yet moved one falling edge after the stimulus. It checks the settled flags only after eight edges of both clocks.

// File: rtl/dcf_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dcf_pkg;
    typedef enum logic {
        XF_STD  = 1'b0,
        XF_FWFT = 1'b1
    } xf_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// Two-stage synchronizer for a Gray-coded pointer vector.
// Assumes: the input changes by at most one bit per source clock edge.
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    // two capture stages in the destination domain, cleared synchronously
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
// Dual-port storage array: synchronous write on the write clock,
// asynchronous read addressed from the read domain.
// Assumes: the pointer logic never reads a location being written.
module dcf_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // store one word per accepted write
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain control: write pointer, full and almost-full flags, and the
// mode-dependent meaning of the shared full/ready flag.
// Assumes: af_lvl <= 2^AW, and rst_n / flush_n are held for several cycles.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_n,
    input  logic          mode_in,
    input  logic          wr_en,
    input  logic [AW:0]   af_lvl,
    input  logic [AW:0]   rgray_in,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          wr_flag,
    output logic          afull
);
    localparam int CW = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [CW-1:0] DEPTH_C = DEPTH[CW-1:0];

    function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
        logic [CW-1:0] b;
        b[CW-1] = g[CW-1];
        for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    xf_mode_e      mode_q;
    logic          fwft;
    logic          clr_n;
    logic [CW-1:0] rq2, rbin_s, wbin, wbin_nxt, wcnt_nxt;
    logic          full_q;

    assign clr_n = rst_n & flush_n;

    dcf_sync #(.W(CW)) u_rsync (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (rgray_in),
        .q     (rq2)
    );

    // latch the operating mode while full reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= xf_mode_e'(mode_in);
    end

    assign fwft = (mode_q == XF_FWFT);

    // next pointer and resulting array occupancy
    always_comb begin
        rbin_s   = g2b(rq2);
        we       = wr_en && !full_q;
        wbin_nxt = wbin + CW'(we);
        wcnt_nxt = wbin_nxt - rbin_s;
    end

    // pointer and registered flags
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_q <= 1'b0;
            afull  <= 1'b0;
        end else begin
            wbin   <= wbin_nxt;
            wgray  <= wbin_nxt ^ (wbin_nxt >> 1);
            full_q <= (wcnt_nxt == DEPTH_C);
            afull  <= (wcnt_nxt > (DEPTH_C - af_lvl));
        end
    end

    assign waddr   = wbin[AW-1:0];
    assign wr_flag = fwft ? !full_q : full_q;

    // R1
    wr_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (wr_en && full_q) |=> $stable(wbin));

    // R12
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (wbin - rbin_s) <= DEPTH_C);
endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain control: read pointer, output register (also the prefetch
// stage in fall-through mode), empty/ready and almost-empty flags, retransmit.
// Assumes: retransmit is requested only while the write port is idle.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_n,
    input  logic          mode_in,
    input  logic          rd_en,
    input  logic          rt_en,
    input  logic          rt_n,
    input  logic [AW:0]   ae_lvl,
    input  logic [AW:0]   wgray_in,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          rd_flag,
    output logic          aempty
);
    localparam int CW = AW + 1;

    function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
        logic [CW-1:0] b;
        b[CW-1] = g[CW-1];
        for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    xf_mode_e      mode_q;
    logic          fwft;
    logic          clr_n;
    logic [CW-1:0] wq2, wbin_s, rbin, rbin_nxt, mcnt_nxt, total_nxt;
    logic          mem_empty_q, ov_q, ov_nxt, rewind, load;

    assign clr_n = rst_n & flush_n;

    dcf_sync #(.W(CW)) u_wsync (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (wgray_in),
        .q     (wq2)
    );

    // latch the operating mode while full reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= xf_mode_e'(mode_in);
    end

    assign fwft = (mode_q == XF_FWFT);

    // decide whether a word leaves the array this cycle, and the next state
    always_comb begin
        wbin_s = g2b(wq2);
        rewind = rt_en && !rt_n;
        if (fwft) load = !mem_empty_q && (!ov_q || rd_en);
        else      load = rd_en && !mem_empty_q;
        if (rewind) begin
            rbin_nxt = '0;
            ov_nxt   = 1'b0;
        end else begin
            rbin_nxt = rbin + CW'(load);
            ov_nxt   = fwft && (load || (ov_q && !rd_en));
        end
        mcnt_nxt  = wbin_s - rbin_nxt;
        total_nxt = mcnt_nxt + CW'(ov_nxt);
    end

    // pointer, prefetch-valid and registered flags
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            rbin        <= '0;
            rgray       <= '0;
            ov_q        <= 1'b0;
            mem_empty_q <= 1'b1;
            aempty      <= 1'b1;
        end else begin
            rbin        <= rbin_nxt;
            rgray       <= rbin_nxt ^ (rbin_nxt >> 1);
            ov_q        <= ov_nxt;
            mem_empty_q <= (mcnt_nxt == '0);
            aempty      <= (total_nxt <= ae_lvl);
        end
    end

    // output data register, loaded by a read or by a fall-through prefetch
    always_ff @(posedge clk) begin
        if (!rst_n)                          dout <= '0;
        else if (flush_n && load && !rewind) dout <= mem_q;
    end

    assign raddr   = rbin[AW-1:0];
    assign rd_flag = fwft ? ov_q : mem_empty_q;

    // R1
    rd_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

    // R11
    no_underflow_chk: assert property (@(posedge clk)
        disable iff (!clr_n || (rt_en && !rt_n))
        (!fwft && rd_en && mem_empty_q) |=> $stable(rbin));

    // R3
    prefetch_hold_chk: assert property (@(posedge clk)
        disable iff (!clr_n || (rt_en && !rt_n))
        (fwft && ov_q && !rd_en) |=> ov_q);
endmodule

// File: rtl/dcfifo_ft.sv
// Dual-clock FIFO top: joins the write-side control, the read-side control
// and the storage array; the Gray pointers cross between the two sides.
// Assumes: rst_n and flush_n stay low for several edges of both clocks.
module dcfifo_ft #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          flush_n,
    input  logic          fwft_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   af_lvl,
    output logic          wr_flag,
    output logic          wr_afull,
    input  logic          rd_en,
    input  logic [AW:0]   ae_lvl,
    input  logic          rt_en,
    input  logic          rt_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          rd_aempty
);
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [AW:0]   wgray, rgray;
    logic [DW-1:0] mem_q;

    dcf_wr_side #(.AW(AW)) u_wr (
        .clk      (wr_clk),
        .rst_n    (rst_n),
        .flush_n  (flush_n),
        .mode_in  (fwft_sel),
        .wr_en    (wr_en),
        .af_lvl   (af_lvl),
        .rgray_in (rgray),
        .we       (we),
        .waddr    (waddr),
        .wgray    (wgray),
        .wr_flag  (wr_flag),
        .afull    (wr_afull)
    );

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    dcf_rd_side #(.DW(DW), .AW(AW)) u_rd (
        .clk      (rd_clk),
        .rst_n    (rst_n),
        .flush_n  (flush_n),
        .mode_in  (fwft_sel),
        .rd_en    (rd_en),
        .rt_en    (rt_en),
        .rt_n     (rt_n),
        .ae_lvl   (ae_lvl),
        .wgray_in (wgray),
        .mem_q    (mem_q),
        .raddr    (raddr),
        .rgray    (rgray),
        .dout     (rd_data),
        .rd_flag  (rd_flag),
        .aempty   (rd_aempty)
    );
endmodule

// File: tb/dcfifo_ft_tb_top.sv
// Self-checking bench: small configuration (8-bit words, 16 locations),
// occupancy swept across the full range in both modes.
module dcfifo_ft_tb_top;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;
    localparam int AE = 3;
    localparam int AF = 4;

    logic wclk = 1'b0, rclk = 1'b0;
    logic rst_n = 1'b0, flush_n = 1'b1, fwft_sel = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, rt_en = 1'b0, rt_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0] af_lvl = AF[AW:0];
    logic [AW:0] ae_lvl = AE[AW:0];
    logic wr_flag, wr_afull, rd_flag, rd_aempty;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcfifo_ft #(.DW(DW), .AW(AW)) dut_i (
        .wr_clk (wclk), .rd_clk (rclk), .rst_n (rst_n), .flush_n (flush_n),
        .fwft_sel (fwft_sel), .wr_en (wr_en), .wr_data (wr_data),
        .af_lvl (af_lvl), .wr_flag (wr_flag), .wr_afull (wr_afull),
        .rd_en (rd_en), .ae_lvl (ae_lvl), .rt_en (rt_en), .rt_n (rt_n),
        .rd_data (rd_data), .rd_flag (rd_flag), .rd_aempty (rd_aempty)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 37 + 5);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic push_raw(input logic [DW-1:0] d);
        @(negedge wclk); wr_en = 1'b1; wr_data = d;
        @(negedge wclk); wr_en = 1'b0;
    endtask

    task automatic push(input logic [DW-1:0] d);
        push_raw(d);
        settle();
    endtask

    task automatic pop();
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        @(negedge wclk); rst_n = 1'b0; fwft_sel = m;
        repeat (12) @(negedge wclk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic do_flush();
        @(negedge wclk); flush_n = 1'b0;
        repeat (12) @(negedge wclk);
        flush_n = 1'b1;
        settle();
    endtask

    task automatic retransmit(input logic en);
        @(negedge rclk); rt_en = en; rt_n = 1'b0;
        repeat (2) @(negedge rclk);
        rt_n = 1'b1; rt_en = 1'b0;
        settle();
    endtask

    // standard-mode flag expectations for c stored words (R4, R5, R6)
    task automatic flags_std(input int c);
        chk("R4 empty", 32'(rd_flag), 32'(c == 0));
        chk("R4 full", 32'(wr_flag), 32'(c == DEPTH));
        chk("R5 aempty", 32'(rd_aempty), 32'(c <= AE));
        chk("R6 afull", 32'(wr_afull), 32'(c > DEPTH - AF));
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        chk("R8 dout", 32'(rd_data), 32'h0);
        flags_std(0);
        // R1: mode input changes after reset are ignored
        @(negedge wclk); fwft_sel = 1'b1;
        settle();
        chk("R1 mode kept", 32'(rd_flag), 32'h1);

        for (int i = 1; i <= DEPTH; i++) begin
            if (i == 1) begin
                push_raw(pat(i));
                @(negedge rclk);
                chk("R7 rd latency", 32'(rd_flag), 32'h1);
                settle();
            end else begin
                push(pat(i));
            end
            chk("R2 no read no data", 32'(rd_data), 32'h0);
            flags_std(i);
        end
        // R11: write while full ignored
        push(8'hEE);
        flags_std(DEPTH);

        for (int i = 1; i <= DEPTH; i++) begin
            pop();
            chk("R2 read data", 32'(rd_data), 32'(pat(i)));
            if (i == 1) begin
                @(negedge wclk);
                chk("R7 wr latency", 32'(wr_flag), 32'h1);
            end
            settle();
            flags_std(DEPTH - i);
        end
        // R11: read while empty ignored
        pop();
        chk("R11 empty read dout", 32'(rd_data), 32'(pat(DEPTH)));
        settle();
        chk("R11 still empty", 32'(rd_flag), 32'h1);
        push(pat(100));
        pop();
        chk("R11 pointer kept", 32'(rd_data), 32'(pat(100)));
        settle();

        // R9: flush in standard mode
        for (int i = 0; i < 5; i++) push(pat(200 + i));
        do_flush();
        flags_std(0);

        // R10: retransmit
        for (int i = 0; i < 4; i++) push(pat(50 + i));
        pop(); chk("R10 pre word0", 32'(rd_data), 32'(pat(50)));
        pop(); chk("R10 pre word1", 32'(rd_data), 32'(pat(51)));
        retransmit(1'b0);
        pop(); chk("R10 rt disabled", 32'(rd_data), 32'(pat(52)));
        retransmit(1'b1);
        chk("R10 data again", 32'(rd_flag), 32'h0);
        for (int i = 0; i < 4; i++) begin
            pop();
            chk("R10 reread", 32'(rd_data), 32'(pat(50 + i)));
        end
        settle();
        chk("R10 drained", 32'(rd_flag), 32'h1);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        chk("R8 fwft not valid", 32'(rd_flag), 32'h0);
        chk("R4 fwft space", 32'(wr_flag), 32'h1);
        chk("R8 fwft aempty", 32'(rd_aempty), 32'h1);
        chk("R8 fwft dout", 32'(rd_data), 32'h0);

        push_raw(pat(300));
        @(negedge rclk);
        chk("R7 fwft latency", 32'(rd_flag), 32'h0);
        settle();
        chk("R3 auto valid", 32'(rd_flag), 32'h1);
        chk("R3 auto data", 32'(rd_data), 32'(pat(300)));
        for (int i = 2; i <= DEPTH + 1; i++) begin
            chk("R12 space left", 32'(wr_flag), 32'h1);
            push(pat(299 + i));
        end
        chk("R12 no space", 32'(wr_flag), 32'h0);
        chk("R3 head kept", 32'(rd_data), 32'(pat(300)));

        for (int i = 1; i <= DEPTH + 1; i++) begin
            chk("R3 head word", 32'(rd_data), 32'(pat(299 + i)));
            pop();
        end
        settle();
        chk("R3 valid dropped", 32'(rd_flag), 32'h0);
        chk("R5 fwft aempty", 32'(rd_aempty), 32'h1);
        pop();
        settle();
        chk("R11 not ready read", 32'(rd_flag), 32'h0);
        chk("R11 not ready dout", 32'(rd_data), 32'(pat(299 + DEPTH + 1)));

        // R9: flush keeps fall-through mode
        for (int i = 0; i < 3; i++) push(pat(400 + i));
        do_flush();
        chk("R9 fwft flag", 32'(rd_flag), 32'h0);
        chk("R9 fwft space", 32'(wr_flag), 32'h1);
        push(pat(500));
        chk("R9 fwft auto", 32'(rd_flag), 32'h1);
        chk("R9 fwft data", 32'(rd_data), 32'(pat(500)));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule